// File: doc/BRIEF.md
# Channel Status and Interrupt Aggregator

This block holds the status word of each DMA audio channel (input, output and microphone by default) and merges those words into one level-sensitive interrupt line. The DMA engine reports events to it as single-cycle pulses, one set for each channel: a buffer has completed, the last valid buffer was reached, the engine has halted, the engine has resumed, or the FIFO has failed. The host clears event bits by writing ones to the channel's status location. Each channel compares its event bits with its two interrupt enables and raises a request. The request is registered into a per-channel global status bit, and the interrupt line stays asserted while any of those bits is set.

Status word layout (16 bits, upper bits read as zero): bit 0 halted, bit 1 end of list, bit 2 last-valid completion, bit 3 buffer completion, bit 4 FIFO error. Channel `c` has its status word at byte address `c*0x10 + 0x6`. Lane 0 of the write covers bits 7:0 and lane 1 covers bits 15:8.

Top module: `chstat_irq_top`

## Requirements
- R1: After a synchronous reset every channel status word reads 0x0001, every global status bit is 0 and `irq` is 0.
- R2: A host write that hits address `c*0x10+6` with byte lane 0 enabled clears those of bits 2, 3 and 4 that carry a 1 in `wr_data`. Bits 0 and 1 cannot be written, so a word write of 0xFFFF to a channel that is in reset state leaves 0x0001.
- R3: A write that only enables lane 1, a write to a different offset, and a write to a channel index at or above NUM_CH all leave every status word unchanged.
- R4: The cycle after an event pulse, the status word shows the effect: buffer-complete sets bit 3, FIFO error sets bit 4, last-valid sets bits 2, 1 and 0, halt sets bit 0, and resume clears bits 0 and 1.
- R5: When a hardware event sets a bit in the same cycle as a host write or a resume clears it, the bit ends up set.
- R6: A channel requests an interrupt only when bit 2 and its last-valid enable are both set, or when bit 3 and its completion enable are both set. FIFO error, halted and end of list never request.
- R7: Global status bit `c` goes to 1 one cycle after channel `c` starts to request, and goes to 0 one cycle after the request ends.
- R8: `irq` is high whenever any global status bit is set. It stays high when one channel drops while another channel still holds its bit, and it goes low only when all of them are clear.
- R9: Events, enables and writes for one channel do not change the status word or global bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_buf_done | input | NUM_CH | Buffer-completion pulse, one bit per channel |
| evt_last_done | input | NUM_CH | Last-valid-buffer-completion pulse |
| evt_halt | input | NUM_CH | Engine-halted pulse |
| evt_resume | input | NUM_CH | Engine-resumed pulse |
| evt_fifo_err | input | NUM_CH | FIFO-error pulse |
| en_last_irq | input | NUM_CH | Last-valid interrupt enable per channel |
| en_done_irq | input | NUM_CH | Completion interrupt enable per channel |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host byte address |
| wr_be | input | 2 | Byte lane enables |
| wr_data | input | 16 | Host write data, ones clear |
| ch_status | output | NUM_CH*16 | Status words, channel c at bits c*16 +: 16 |
| glob_int | output | NUM_CH | Global per-channel interrupt status |
| irq | output | 1 | Shared level interrupt |

## Verification
The bench targets the halted bit under an all-ones write. A design that let it be written would read 0x0000 instead of 0x0001. It also checks that a set and a clear arriving in the same cycle leave the bit set, where a design with the wrong priority would silently lose an event. Another test enables one source and raises only the other, so a design that crossed the two enables would raise a request that should not exist. The shared line is watched while channels drop out one at a time: a design that deasserted on the first channel to drop, or that missed the one-cycle registration delay, shows up as a wrong `irq` or `glob_int` value.

// File: rtl/chstat_pkg.sv
// Package: constants shared by the channel status blocks.
// Assumes a 16-bit status word with all defined bits in the low byte.
package chstat_pkg;
    localparam int STS_W = 16;

    // Status word bit positions (software decodes these)
    localparam int B_HALT = 0;
    localparam int B_EOL  = 1;
    localparam int B_LVC  = 2;
    localparam int B_BC   = 3;
    localparam int B_FE   = 4;

    localparam logic [STS_W-1:0] STS_RESET = 16'h0001;
    // Bits the host may clear by writing one
    localparam logic [STS_W-1:0] W1C_MASK  = 16'h001C;
endpackage

// File: rtl/chstat_wr_dec.sv
// Module: chstat_wr_dec
// Turns one host write into a per-channel clear mask. Channel c owns
// the status word at byte address c*CH_STRIDE + STS_OFS. Assumes the
// address space holds every channel (NUM_CH*CH_STRIDE <= 2**ADDR_W).
module chstat_wr_dec
    import chstat_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 6,
    parameter int CH_STRIDE = 16,
    parameter int STS_OFS   = 6
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [1:0]              wr_be,
    input  logic [STS_W-1:0]        wr_data,
    output logic [NUM_CH*STS_W-1:0] clr_mask
);
    logic [STS_W-1:0] lane_data;

    // Keep only data bytes whose lane is enabled, then only W1C bits
    always_comb begin
        lane_data = wr_data & {{8{wr_be[1]}}, {8{wr_be[0]}}} & W1C_MASK;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(c*CH_STRIDE + STS_OFS);
        // Route the masked data to the channel whose address matches
        always_comb begin
            clr_mask[c*STS_W +: STS_W] =
                (wr_en && (wr_addr == CH_ADDR)) ? lane_data : '0;
        end
    end
endmodule

// File: rtl/chstat_chan.sv
// Module: chstat_chan
// One channel's status word. Applies host clears first, then resume,
// then hardware sets, so a set beats a clear in the same cycle.
// Produces the channel interrupt request from bits and enables.
// Assumes event inputs are single-cycle pulses.
module chstat_chan
    import chstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bc,
    input  logic             ev_lv,
    input  logic             ev_halt,
    input  logic             ev_resume,
    input  logic             ev_fe,
    input  logic             en_lv,
    input  logic             en_bc,
    input  logic [STS_W-1:0] clr,
    output logic [STS_W-1:0] sts,
    output logic             req
);
    logic [STS_W-1:0] sts_nxt;

    // Next-state of the status word: clear, resume, then set
    always_comb begin
        sts_nxt = sts & ~(clr & W1C_MASK);
        if (ev_resume) begin
            sts_nxt[B_HALT] = 1'b0;
            sts_nxt[B_EOL]  = 1'b0;
        end
        if (ev_bc) sts_nxt[B_BC] = 1'b1;
        if (ev_fe) sts_nxt[B_FE] = 1'b1;
        if (ev_lv) begin
            sts_nxt[B_LVC]  = 1'b1;
            sts_nxt[B_EOL]  = 1'b1;
            sts_nxt[B_HALT] = 1'b1;
        end
        if (ev_halt) sts_nxt[B_HALT] = 1'b1;
    end

    // Status register with synchronous reset to the halted state
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= STS_RESET;
        else        sts <= sts_nxt;
    end

    // Interrupt request from enabled event bits
    always_comb begin
        req = (sts[B_LVC] & en_lv) | (sts[B_BC] & en_bc);
    end

    // R4: completion event shows in the status word next cycle
    p_bc_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bc |=> sts[B_BC]);
    // R4: halt event leaves the halted bit set
    p_halt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> sts[B_HALT]);
    // R5: set wins over a host clear in the same cycle
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bc && clr[B_BC]) |=> sts[B_BC]);
    // R2: a host clear without a competing set empties the bit
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[B_BC] && !ev_bc) |=> !sts[B_BC]);
    // R2: halted only leaves on resume, never on a host write
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[B_HALT] && !ev_resume) |=> sts[B_HALT]);
    // R6: FIFO error alone never requests
    p_fe_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts[B_LVC] && !sts[B_BC]) |-> !req);
endmodule

// File: rtl/chstat_irq_agg.sv
// Module: chstat_irq_agg
// Registers each channel request into a global status bit and drives
// the shared level interrupt from them. The line falls only once all
// global bits are clear. Assumes requests are synchronous to clk.
module chstat_irq_agg #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] glob,
    output logic              irq
);
    // Global status follows the channel requests, one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) glob <= '0;
        else        glob <= req;
    end

    // Shared line: high while any channel bit remains
    always_comb begin
        irq = |glob;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R7: a request appears in global status next cycle
        p_glob_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            req[c] |=> glob[c]);
        // R7: a dropped request clears global status next cycle
        p_glob_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !req[c] |=> !glob[c]);
    end

    // R8: any request holds the line high next cycle
    p_irq_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> irq);
    // R8: line drops only when no channel requested
    p_irq_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !irq);
endmodule

// File: rtl/chstat_irq_top.sv
// Module: chstat_irq_top
// Channel status words plus interrupt aggregation. One status channel
// per DMA channel, a host write decoder, and the shared interrupt.
// Assumes all inputs are synchronous to clk.
module chstat_irq_top
    import chstat_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 6,
    parameter int CH_STRIDE = 16,
    parameter int STS_OFS   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       evt_buf_done,
    input  logic [NUM_CH-1:0]       evt_last_done,
    input  logic [NUM_CH-1:0]       evt_halt,
    input  logic [NUM_CH-1:0]       evt_resume,
    input  logic [NUM_CH-1:0]       evt_fifo_err,
    input  logic [NUM_CH-1:0]       en_last_irq,
    input  logic [NUM_CH-1:0]       en_done_irq,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [1:0]              wr_be,
    input  logic [15:0]             wr_data,
    output logic [NUM_CH*16-1:0]    ch_status,
    output logic [NUM_CH-1:0]       glob_int,
    output logic                    irq
);
    logic [NUM_CH*STS_W-1:0] clr_mask;
    logic [NUM_CH-1:0]       ch_req;

    chstat_wr_dec #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
        .CH_STRIDE(CH_STRIDE), .STS_OFS(STS_OFS)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .clr_mask(clr_mask)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chstat_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_bc    (evt_buf_done[c]),
            .ev_lv    (evt_last_done[c]),
            .ev_halt  (evt_halt[c]),
            .ev_resume(evt_resume[c]),
            .ev_fe    (evt_fifo_err[c]),
            .en_lv    (en_last_irq[c]),
            .en_bc    (en_done_irq[c]),
            .clr      (clr_mask[c*STS_W +: STS_W]),
            .sts      (ch_status[c*16 +: 16]),
            .req      (ch_req[c])
        );
    end

    chstat_irq_agg #(.NUM_CH(NUM_CH)) u_agg (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (ch_req),
        .glob (glob_int),
        .irq  (irq)
    );
endmodule

// File: tb/tb_chstat_irq_top.sv
`timescale 1ns/1ps
module tb_chstat_irq_top;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] ev_bc, ev_lv, ev_halt, ev_res, ev_fe, en_lv, en_bc;
    logic wr_en;
    logic [5:0] wr_addr;
    logic [1:0] wr_be;
    logic [15:0] wr_data;
    logic [NCH*16-1:0] ch_status;
    logic [NCH-1:0] glob_int;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    chstat_irq_top dut (
        .clk(clk), .rst_n(rst_n),
        .evt_buf_done(ev_bc), .evt_last_done(ev_lv), .evt_halt(ev_halt),
        .evt_resume(ev_res), .evt_fifo_err(ev_fe),
        .en_last_irq(en_lv), .en_done_irq(en_bc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .ch_status(ch_status), .glob_int(glob_int), .irq(irq)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] sts(input int c);
        return ch_status[c*16 +: 16];
    endfunction

    // Host write, returns at the negedge after the capturing edge
    task automatic hwrite(input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
    endtask

    // Event pulse: kind 0 done,1 last,2 halt,3 resume,4 fifo
    task automatic pulse(input int kind, input int c);
        @(negedge clk);
        case (kind)
            0: ev_bc[c] = 1'b1;
            1: ev_lv[c] = 1'b1;
            2: ev_halt[c] = 1'b1;
            3: ev_res[c] = 1'b1;
            default: ev_fe[c] = 1'b1;
        endcase
        @(negedge clk);
        ev_bc = '0; ev_lv = '0; ev_halt = '0; ev_res = '0; ev_fe = '0;
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) chk("R1 status", sts(c), 16'h0001);
        chk("R1 glob", 16'(glob_int), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
    endtask

    task automatic t_w1c();
        hwrite(6'h06, 2'b11, 16'hFFFF);
        chk("R2 all-ones keeps halted", sts(0), 16'h0001);
        pulse(0, 1);
        chk("R4 done sets bit3", sts(1), 16'h0009);
        pulse(4, 1);
        chk("R4 fifo sets bit4", sts(1), 16'h0019);
        hwrite(6'h16, 2'b01, 16'h0008);
        chk("R2 byte clear bit3", sts(1), 16'h0011);
        hwrite(6'h16, 2'b11, 16'h0010);
        chk("R2 word clear bit4", sts(1), 16'h0001);
    endtask

    task automatic t_ignored();
        pulse(0, 2);
        chk("R4 done ch2", sts(2), 16'h0009);
        hwrite(6'h26, 2'b10, 16'hFFFF);
        chk("R3 upper lane only", sts(2), 16'h0009);
        hwrite(6'h24, 2'b11, 16'hFFFF);
        chk("R3 wrong offset", sts(2), 16'h0009);
        hwrite(6'h36, 2'b11, 16'hFFFF);
        chk("R3 absent channel", sts(2), 16'h0009);
        chk("R9 ch0 untouched", sts(0), 16'h0001);
        chk("R9 ch1 untouched", sts(1), 16'h0001);
        hwrite(6'h26, 2'b01, 16'h00FF);
        chk("R2 clear ch2", sts(2), 16'h0001);
    endtask

    task automatic t_last_resume();
        pulse(3, 1);
        chk("R4 resume clears halted", sts(1), 16'h0000);
        pulse(1, 1);
        chk("R4 last sets bits 2..0", sts(1), 16'h0007);
        hwrite(6'h16, 2'b01, 16'h00FF);
        chk("R2 clear leaves halted/eol", sts(1), 16'h0003);
        pulse(3, 1);
        chk("R4 resume clears 1..0", sts(1), 16'h0000);
        pulse(2, 1);
        chk("R4 halt sets bit0", sts(1), 16'h0001);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        ev_bc[0] = 1'b1;
        wr_en = 1'b1; wr_addr = 6'h06; wr_be = 2'b01; wr_data = 16'h0008;
        @(negedge clk);
        ev_bc = '0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
        chk("R5 done beats host clear", sts(0), 16'h0009);
        @(negedge clk);
        ev_halt[2] = 1'b1; ev_res[2] = 1'b1;
        @(negedge clk);
        ev_halt = '0; ev_res = '0;
        chk("R5 halt beats resume", sts(2), 16'h0001);
    endtask

    task automatic t_irq();
        // ch0 holds bit3, no enables yet
        @(negedge clk);
        chk("R6 no enable no glob", 16'(glob_int), 16'h0);
        chk("R6 no enable no irq", 16'(irq), 16'h0);
        en_lv[0] = 1'b1;   // wrong enable for bit3
        @(negedge clk);
        @(negedge clk);
        chk("R6 crossed enable ignored", 16'(glob_int), 16'h0);
        en_lv[0] = 1'b0; en_bc[0] = 1'b1;
        @(negedge clk);
        chk("R7 glob ch0 set", 16'(glob_int), 16'h1);
        chk("R8 irq high", 16'(irq), 16'h1);
        en_lv[2] = 1'b1; en_bc[2] = 1'b1;
        pulse(4, 2);
        @(negedge clk);
        chk("R6 fifo/halt no request", 16'(glob_int), 16'h1);
        en_lv[1] = 1'b1;
        pulse(1, 1);
        chk("R7 glob lags status", 16'(glob_int), 16'h1);
        @(negedge clk);
        chk("R7 glob ch1 set", 16'(glob_int), 16'h3);
        hwrite(6'h06, 2'b01, 16'h0008);
        @(negedge clk);
        chk("R7 glob ch0 cleared", 16'(glob_int), 16'h2);
        chk("R8 irq held by ch1", 16'(irq), 16'h1);
        chk("R9 ch1 status kept", sts(1), 16'h0007);
        hwrite(6'h16, 2'b01, 16'h0004);
        chk("R7 glob lags clear", 16'(glob_int), 16'h2);
        @(negedge clk);
        chk("R8 all clear glob", 16'(glob_int), 16'h0);
        chk("R8 irq low", 16'(irq), 16'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        ev_bc = '0; ev_lv = '0; ev_halt = '0; ev_res = '0; ev_fe = '0;
        en_lv = '0; en_bc = '0;
        wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w1c();
        t_ignored();
        t_last_resume();
        t_set_wins();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule